// File: doc/BRIEF.md
# Vector Length Control Unit

This unit keeps a 32-bit vector state word for prefixed vector instructions. It applies the 12-bit length-control field carried by each such instruction. Decode presents the field together with a strobe. If the field selects a scalar register, decode also presents that register's value. The unit then sets the current vector length, the maximum vector length, or both. It also returns the new length as a scalar register write.

The field is decoded from its top bit and its bottom bit. With the top bit clear, the instruction sets only the length: either from a 5-bit immediate biased by one, or from a register value clamped to the current maximum. With the top bit set, the instruction writes a new maximum from the biased immediate. In that mode the length is either set to the same value, or cut down to the new maximum only if it exceeded it. An all-zero field leaves the state alone.

Two option inputs say whether length overrides and sub-vector fields are supported. Encodings that are not supported raise a one-cycle illegal-instruction pulse instead of changing state. The same applies to encodings that are out of range. A CSR-style port reads and writes the whole state word and rejects writes to reserved or unsupported bits.

Top module: `vlen_ctl_unit`

## Requirements
- R1: After reset the state word, VL and MAXVL are zero, and the write-back enable and illegal flag are low.
- R2: A strobed length field of all zeros changes no state, makes no write-back and raises no illegal flag.
- R3: With field bit 11 = 0 and bit 0 = 0, VL becomes field[5:1] + 1 and MAXVL is unchanged.
- R4: With field bit 11 = 0 and bit 0 = 1, VL becomes the minimum of the source register value and the current MAXVL. Field[5:1] names the source register, and naming register 0 is illegal.
- R5: With field bit 11 = 1 and bit 0 = 0, both MAXVL and VL become field[5:1] + 1.
- R6: With field bit 11 = 1 and bit 0 = 1, MAXVL becomes field[5:1] + 1, and VL is lowered to that value only if it was larger.
- R7: Every accepted nonzero field makes a write-back one clock after the strobe: index field[10:6], data equal to the new VL. The write-back is suppressed when the index is 0.
- R8: Every accepted nonzero field also clears the source offset (bits 17:12), destination offset (bits 23:18) and sub-vector offset (bits 27:26) in the same update, and keeps the sub-vector length (bits 25:24).
- R9: An immediate length (field[5:1] + 1) above the MAX_VL parameter is illegal in modes R3, R5 and R6. A length equal to MAX_VL is legal.
- R10: When the length-override option is off, any nonzero field is illegal.
- R11: The state word is laid out as MAXVL bits 5:0, VL bits 11:6, offsets and sub-vector length as in R8, and bits 31:28 reserved. A CSR write is accepted and read back unless it sets a reserved bit, or sets bits 27:24 while the sub-vector option is off. A rejected write is illegal.
- R12: The illegal flag is a single-cycle pulse in the cycle after the offending strobe. When it fires, the state is unchanged and no write-back is made.
- R13: When a CSR write and a length strobe arrive together, the length update is applied and the CSR write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Strobe: a prefixed instruction's length field is present |
| vlTyp | input | 12 | Length-control field |
| srcRegVal | input | XLEN | Value of the scalar register named by vlTyp[5:1] |
| optVlOvr | input | 1 | Length override supported |
| optSubVec | input | 1 | Sub-vector fields supported |
| csrWe | input | 1 | State word write strobe |
| csrWdata | input | 32 | State word write data |
| csrRdata | output | 32 | Current state word |
| vlOut | output | 6 | Current VL |
| maxVlOut | output | 6 | Current MAXVL |
| wbEn | output | 1 | Scalar write-back valid |
| wbIdx | output | 5 | Scalar write-back register index |
| wbData | output | XLEN | Scalar write-back value |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
A table of length fields is stepped through all four modes in a chain. Each step starts from the state the previous one left. This separates an immediate-set length from a register-set length, and a clamping register value from a passing one. It also separates a truncating maximum from one that leaves VL alone. Boundary entries place the immediate at MAX_VL and one above it, and use register 0 and write-back index 0. Directed CSR sequences preload nonzero offsets to show that they are cleared. They also show reserved-bit and option-gated rejections, the single-cycle illegal pulse, and the precedence of a simultaneous strobe over a CSR write.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int FIELD_W = 12;
  localparam int LEN_W   = 6;
  localparam int IDX_W   = 5;
  localparam int STATE_W = 32;

  typedef struct packed {
    logic [3:0]       rsvd;
    logic [1:0]       subOffs;
    logic [1:0]       subLen;
    logic [LEN_W-1:0] dstOffs;
    logic [LEN_W-1:0] srcOffs;
    logic [LEN_W-1:0] vl;
    logic [LEN_W-1:0] maxVl;
  } vstate_t;

  typedef struct packed {
    logic setVlImm;
    logic setVlReg;
    logic setBoth;
    logic setMaxTrunc;
    logic csrLoad;
    logic writeBack;
  } vstrobe_t;
endpackage

// File: rtl/vlc_ctrl.sv
module vlc_ctrl
  import vlc_pkg::*;
#(
  parameter int MAX_VL = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               decValid,
  input  logic [FIELD_W-1:0] vlTyp,
  input  logic               optVlOvr,
  input  logic               optSubVec,
  input  logic               csrWe,
  input  logic [STATE_W-1:0] csrWdata,
  output vstrobe_t           stb,
  output logic               illegalQ
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_VL);

  logic             fieldZero, hiBit, loBit, regMode, immTooBig, decIll, decOk;
  logic             csrIll, csrOk;
  logic [LEN_W-1:0] immLen;
  logic [STATE_W-1:0] legalMask;

  assign fieldZero = (vlTyp == '0);
  assign hiBit     = vlTyp[FIELD_W-1];
  assign loBit     = vlTyp[0];
  assign regMode   = !hiBit && loBit;
  assign immLen    = LEN_W'(vlTyp[5:1]) + LEN_W'(1);
  assign immTooBig = !regMode && (immLen > MAX_LEN);

  assign decIll = decValid && !fieldZero &&
                  (!optVlOvr || (regMode && vlTyp[5:1] == '0) || immTooBig);
  assign decOk  = decValid && !fieldZero && !decIll;

  assign legalMask = optSubVec ? STATE_W'(32'h0FFF_FFFF) : STATE_W'(32'h00FF_FFFF);
  assign csrIll    = csrWe && !decValid && ((csrWdata & ~legalMask) != '0);
  assign csrOk     = csrWe && !decValid && !csrIll;

  always_comb begin
    stb             = '0;
    stb.setVlImm    = decOk && !hiBit && !loBit;
    stb.setVlReg    = decOk && regMode;
    stb.setBoth     = decOk && hiBit && !loBit;
    stb.setMaxTrunc = decOk && hiBit && loBit;
    stb.csrLoad     = csrOk;
    stb.writeBack   = decOk && (vlTyp[10:6] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) illegalQ <= 1'b0;
    else       illegalQ <= decIll || csrIll;
  end

  // R3 R4 R5 R6 R13
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setVlImm, stb.setVlReg, stb.setBoth, stb.setMaxTrunc, stb.csrLoad}));

  // R7
  wb_needs_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeBack |-> (stb.setVlImm || stb.setVlReg || stb.setBoth || stb.setMaxTrunc));
endmodule

// File: rtl/vlc_dpath.sv
module vlc_dpath
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  vstrobe_t           stb,
  input  logic [FIELD_W-1:0] vlTyp,
  input  logic [XLEN-1:0]    srcRegVal,
  input  logic [STATE_W-1:0] csrWdata,
  output vstate_t            stateQ,
  output logic               wbEnQ,
  output logic [IDX_W-1:0]   wbIdxQ,
  output logic [XLEN-1:0]    wbDataQ
);
  logic [LEN_W-1:0] immLen, regLen, newVl, newMax;
  logic             anyVlSet;
  vstate_t          stateD;

  assign immLen   = LEN_W'(vlTyp[5:1]) + LEN_W'(1);
  assign regLen   = (srcRegVal < XLEN'(stateQ.maxVl)) ? srcRegVal[LEN_W-1:0] : stateQ.maxVl;
  assign anyVlSet = stb.setVlImm || stb.setVlReg || stb.setBoth || stb.setMaxTrunc;

  always_comb begin
    newVl  = stateQ.vl;
    newMax = stateQ.maxVl;
    if (stb.setVlImm) newVl = immLen;
    if (stb.setVlReg) newVl = regLen;
    if (stb.setBoth) begin
      newVl  = immLen;
      newMax = immLen;
    end
    if (stb.setMaxTrunc) begin
      newMax = immLen;
      newVl  = (stateQ.vl > immLen) ? immLen : stateQ.vl;
    end
  end

  always_comb begin
    stateD = stateQ;
    if (stb.csrLoad) begin
      stateD = vstate_t'(csrWdata);
    end else if (anyVlSet) begin
      stateD.vl      = newVl;
      stateD.maxVl   = newMax;
      stateD.srcOffs = '0;
      stateD.dstOffs = '0;
      stateD.subOffs = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= '0;
      wbEnQ   <= 1'b0;
      wbIdxQ  <= '0;
      wbDataQ <= '0;
    end else begin
      stateQ <= stateD;
      wbEnQ  <= stb.writeBack;
      if (stb.writeBack) begin
        wbIdxQ  <= vlTyp[10:6];
        wbDataQ <= XLEN'(newVl);
      end
    end
  end

  // R6
  trunc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.setMaxTrunc) |-> (stateQ.vl <= stateQ.maxVl));

  // R8
  offs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(anyVlSet) |-> (stateQ.srcOffs == '0 && stateQ.dstOffs == '0 && stateQ.subOffs == '0));

  // R7
  wb_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEnQ |-> (wbIdxQ != '0));

  // R11
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateQ.rsvd == '0);
endmodule

// File: rtl/vlen_ctl_unit.sv
module vlen_ctl_unit
  import vlc_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int MAX_VL = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic [11:0]       vlTyp,
  input  logic [XLEN-1:0]   srcRegVal,
  input  logic              optVlOvr,
  input  logic              optSubVec,
  input  logic              csrWe,
  input  logic [31:0]       csrWdata,
  output logic [31:0]       csrRdata,
  output logic [5:0]        vlOut,
  output logic [5:0]        maxVlOut,
  output logic              wbEn,
  output logic [4:0]        wbIdx,
  output logic [XLEN-1:0]   wbData,
  output logic              illegal
);
  vstrobe_t stb;
  vstate_t  stateQ;

  vlc_ctrl #(.MAX_VL(MAX_VL)) i_ctrl (
    .clk(clk), .rstN(rstN), .decValid(decValid), .vlTyp(vlTyp),
    .optVlOvr(optVlOvr), .optSubVec(optSubVec), .csrWe(csrWe),
    .csrWdata(csrWdata), .stb(stb), .illegalQ(illegal)
  );

  vlc_dpath #(.XLEN(XLEN)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .vlTyp(vlTyp), .srcRegVal(srcRegVal),
    .csrWdata(csrWdata), .stateQ(stateQ), .wbEnQ(wbEn), .wbIdxQ(wbIdx),
    .wbDataQ(wbData)
  );

  assign csrRdata = stateQ;
  assign vlOut    = stateQ.vl;
  assign maxVlOut = stateQ.maxVl;

  // R12
  ill_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $stable(csrRdata));

  // R12
  ill_no_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !wbEn);
endmodule

// File: tb/test_vlen_ctl_unit.sv
module test_vlen_ctl_unit;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            decValid = 1'b0;
  logic [11:0]     vlTyp = '0;
  logic [XLEN-1:0] srcRegVal = '0;
  logic            optVlOvr = 1'b1;
  logic            optSubVec = 1'b1;
  logic            csrWe = 1'b0;
  logic [31:0]     csrWdata = '0;
  logic [31:0]     csrRdata;
  logic [5:0]      vlOut, maxVlOut;
  logic            wbEn, illegal;
  logic [4:0]      wbIdx;
  logic [XLEN-1:0] wbData;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  vlen_ctl_unit #(.XLEN(XLEN), .MAX_VL(20)) i_vlen_ctl_unit (
    .clk(clk), .rstN(rstN), .decValid(decValid), .vlTyp(vlTyp),
    .srcRegVal(srcRegVal), .optVlOvr(optVlOvr), .optSubVec(optSubVec),
    .csrWe(csrWe), .csrWdata(csrWdata), .csrRdata(csrRdata), .vlOut(vlOut),
    .maxVlOut(maxVlOut), .wbEn(wbEn), .wbIdx(wbIdx), .wbData(wbData),
    .illegal(illegal)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [11:0] typ;
    logic [7:0]  rv;
    logic [5:0]  eVl;
    logic [5:0]  eMax;
    logic        eWb;
    logic [4:0]  eIdx;
    logic [5:0]  eData;
    logic        eIll;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{4'd5, {1'b1, 5'd3, 5'd7,  1'b0}, 8'd0,  6'd8,  6'd8,  1'b1, 5'd3, 6'd8,  1'b0}, // R5
    '{4'd3, {1'b0, 5'd0, 5'd4,  1'b0}, 8'd0,  6'd5,  6'd8,  1'b0, 5'd0, 6'd0,  1'b0}, // R3 R7 idx 0
    '{4'd4, {1'b0, 5'd5, 5'd2,  1'b1}, 8'd30, 6'd8,  6'd8,  1'b1, 5'd5, 6'd8,  1'b0}, // R4 clamp
    '{4'd4, {1'b0, 5'd5, 5'd2,  1'b1}, 8'd3,  6'd3,  6'd8,  1'b1, 5'd5, 6'd3,  1'b0}, // R4 pass
    '{4'd6, {1'b1, 5'd1, 5'd9,  1'b1}, 8'd0,  6'd3,  6'd10, 1'b1, 5'd1, 6'd3,  1'b0}, // R6 keep
    '{4'd6, {1'b1, 5'd1, 5'd1,  1'b1}, 8'd0,  6'd2,  6'd2,  1'b1, 5'd1, 6'd2,  1'b0}, // R6 cut
    '{4'd2, 12'd0,                      8'd0,  6'd2,  6'd2,  1'b0, 5'd0, 6'd0,  1'b0}, // R2
    '{4'd4, {1'b0, 5'd4, 5'd0,  1'b1}, 8'd9,  6'd2,  6'd2,  1'b0, 5'd0, 6'd0,  1'b1}, // R4 reg 0
    '{4'd9, {1'b1, 5'd2, 5'd20, 1'b0}, 8'd0,  6'd2,  6'd2,  1'b0, 5'd0, 6'd0,  1'b1}, // R9 over
    '{4'd9, {1'b1, 5'd2, 5'd19, 1'b0}, 8'd0,  6'd20, 6'd20, 1'b1, 5'd2, 6'd20, 1'b0}, // R9 edge
    '{4'd9, {1'b0, 5'd2, 5'd31, 1'b0}, 8'd0,  6'd20, 6'd20, 1'b0, 5'd0, 6'd0,  1'b1}, // R9 loop
    '{4'd6, {1'b1, 5'd7, 5'd0,  1'b1}, 8'd0,  6'd1,  6'd1,  1'b1, 5'd7, 6'd1,  1'b0}  // R6 min
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic decode(input logic [11:0] typ, input logic [XLEN-1:0] rv, input logic alsoCsr,
                        input logic [31:0] wd);
    @(negedge clk);
    decValid  = 1'b1;
    vlTyp     = typ;
    srcRegVal = rv;
    csrWe     = alsoCsr;
    csrWdata  = wd;
    @(negedge clk);
    decValid = 1'b0;
    csrWe    = 1'b0;
  endtask

  task automatic csrWrite(input logic [31:0] wd);
    @(negedge clk);
    csrWe    = 1'b1;
    csrWdata = wd;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  function automatic logic [31:0] packState(input int mx, input int vl, input int so,
                                            input int dso, input int sl, input int sso);
    return 32'(mx) | (32'(vl) << 6) | (32'(so) << 12) | (32'(dso) << 18) |
           (32'(sl) << 24) | (32'(sso) << 26);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", csrRdata, 0);
    chk("R1 vl", vlOut, 0);
    chk("R1 maxvl", maxVlOut, 0);
    chk("R1 wbEn", wbEn, 0);
    chk("R1 illegal", illegal, 0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      decode(VECS[i].typ, XLEN'(VECS[i].rv), 1'b0, 32'd0);
      chk({tag, " vl"}, vlOut, VECS[i].eVl);
      chk({tag, " maxvl"}, maxVlOut, VECS[i].eMax);
      chk({tag, " wbEn"}, wbEn, VECS[i].eWb);
      chk({tag, " illegal"}, illegal, VECS[i].eIll);
      if (VECS[i].eWb) begin
        chk({tag, " wbIdx"}, wbIdx, VECS[i].eIdx);
        chk({tag, " wbData"}, wbData, XLEN'(VECS[i].eData));
      end
    end

    // R11 legal write and read-back
    csrWrite(packState(12, 9, 5, 6, 2, 1));
    chk("R11 readback", csrRdata, packState(12, 9, 5, 6, 2, 1));
    chk("R11 vl field", vlOut, 9);
    chk("R11 no illegal", illegal, 0);

    // R8 offsets cleared by a loop-mode set, sub-vector length kept
    decode({1'b0, 5'd0, 5'd2, 1'b0}, '0, 1'b0, 32'd0);
    chk("R8 state", csrRdata, packState(12, 3, 0, 0, 2, 0));

    // R11 reserved bit rejected
    snap = csrRdata;
    csrWrite(snap | 32'h4000_0000);
    chk("R11 rsvd illegal", illegal, 1);
    chk("R11 rsvd unchanged", csrRdata, snap);
    @(negedge clk);
    // R12 pulse lasts one cycle
    chk("R12 pulse end", illegal, 0);

    // R11 sub-vector bits rejected when option off
    optSubVec = 1'b0;
    csrWrite(packState(4, 4, 0, 0, 1, 0));
    chk("R11 subvec illegal", illegal, 1);
    chk("R11 subvec unchanged", csrRdata, snap);
    optSubVec = 1'b1;

    // R10 override option off
    optVlOvr = 1'b0;
    decode({1'b1, 5'd3, 5'd3, 1'b0}, '0, 1'b0, 32'd0);
    chk("R10 illegal", illegal, 1);
    chk("R10 state kept", csrRdata, snap);
    chk("R12 no wb", wbEn, 0);
    decode(12'd0, '0, 1'b0, 32'd0);
    chk("R10 zero field legal", illegal, 0);
    optVlOvr = 1'b1;

    // R13 strobe beats simultaneous CSR write
    decode({1'b0, 5'd0, 5'd5, 1'b0}, '0, 1'b1, packState(1, 1, 0, 0, 0, 0));
    chk("R13 state", csrRdata, packState(12, 6, 0, 0, 2, 0));
    chk("R13 no illegal", illegal, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule